// File: doc/BRIEF.md
# Receive Sampling Tuning Sweep Engine

This engine searches for the best receive sampling delay tap of a high-speed card interface. After a start pulse it walks the tap index upward from zero. For every tap it places the tap on the tune bus and raises a tune-update request. It holds that request until the datapath acknowledges that the delay has been applied. Each tap is applied twice in a row to work around a receive-path timing hazard. Once both updates are acknowledged, the engine launches one tuning-pattern transfer. An external checker then returns pass or fail.

While sweeping, the engine keeps the length of the current run of passing taps. It also keeps the longest run seen so far and the tap on which that run ended. When the sweep is over, it programs the centre of the longest run, again as a double update, and then pulses done. If no tap passed, it pulses an error and programs nothing. An update that is never acknowledged is abandoned after a bounded wait, and that tap counts as failing.

Top module: `tsw_sweep_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `upd_req_o`, `xfer_start_o`, `tap_o`, `best_tap_o` and `win_len_o` are all zero.
- R2: A sweep presents taps 0, 1, … TAP_COUNT-1 in ascending order. Each tap is requested exactly twice, with `upd_req_o` low for at least one cycle between the two requests. `tap_o` holds steady while `upd_req_o` is high and never exceeds TAP_COUNT-1.
- R3: `upd_req_o` stays high until `upd_ack_i` is seen, for at most UPD_TIMEOUT cycles. If no acknowledge arrives, the request drops after exactly UPD_TIMEOUT cycles and the tap is counted as failing, with no transfer launched for it.
- R4: `xfer_start_o` is a one-cycle pulse, issued only after both updates of a tap are acknowledged and never while `upd_req_o` is high. The tap passes when `xfer_done_i` is high together with `xfer_pass_i` high.
- R5: A failing tap resets the current run to zero. A passing tap extends it by one. When the extended run is strictly longer than the best run, that length and the current tap are recorded.
- R6: A later run of equal length to the best run does not replace the earlier one.
- R7: After the last tap, the engine programs tap = end_tap − floor(best_len/2) with two update requests. It then pulses `done_o` for one cycle. `best_tap_o` and `win_len_o` hold the chosen tap and run length until the next start.
- R8: If no tap passed, `err_o` pulses for one cycle. No final update is issued, `done_o` stays low and `win_len_o` reads 0. `done_o` and `err_o` are never high together.
- R9: `start_i` is ignored while a sweep is in progress. The sweep continues without restarting.
- R10: `busy_o` is high from the cycle after an accepted start up to the cycle before the `done_o` or `err_o` pulse, and low during that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a sweep when idle |
| tap_o | output | TAP_W | Tap value presented to the tune register |
| upd_req_o | output | 1 | Tune-update request, held until acknowledged or timed out |
| upd_ack_i | input | 1 | Datapath has applied the tap |
| xfer_start_o | output | 1 | Launch one tuning-pattern transfer |
| xfer_done_i | input | 1 | Transfer result valid |
| xfer_pass_i | input | 1 | Transfer passed (sampled with `xfer_done_i`) |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse: centre tap programmed |
| err_o | output | 1 | One-cycle pulse: no passing tap or final update failed |
| best_tap_o | output | TAP_W | Chosen tap |
| win_len_o | output | $clog2(TAP_COUNT+1) | Length of the chosen passing run |

## Verification
The bench keeps the default span of 40 taps. This makes the boundary taps 0 and 39 reachable, as well as a run that covers the whole range. UPD_TIMEOUT is lowered to 6, so an unacknowledged update expires within a few cycles. The length of that abandoned request can then be measured exactly against the timeout. Pass maps with ties, a single edge tap, no passing tap and a run split by a stuck update exercise the run bookkeeping and the centre arithmetic.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UPD,
        S_XFER,
        S_NEXT,
        S_FINAL
    } seq_state_e;

    typedef enum logic [1:0] {
        U_IDLE,
        U_REQ,
        U_GAP
    } upd_state_e;

endpackage

// File: rtl/tsw_upd_issuer.sv
// Issues the double tune-update handshake for one tap, with a bounded wait.
module tsw_upd_issuer
    import tsw_pkg::*;
#(
    parameter int UPD_TIMEOUT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    input  logic ack_i,
    output logic req_o,
    output logic done_o,
    output logic ok_o
);
    localparam int TMR_W = $clog2(UPD_TIMEOUT + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(UPD_TIMEOUT - 1);

    typedef struct packed {
        upd_state_e       st;
        logic             second;
        logic [TMR_W-1:0] tmr;
        logic             done;
        logic             ok;
    } iss_t;

    iss_t iss_d, iss_q;

    always_comb begin
        iss_d      = iss_q;
        iss_d.done = 1'b0;
        iss_d.ok   = 1'b0;
        unique case (iss_q.st)
            U_IDLE: begin
                if (go_i) begin
                    iss_d.st     = U_REQ;
                    iss_d.second = 1'b0;
                    iss_d.tmr    = '0;
                end
            end
            U_REQ: begin
                if (ack_i) begin
                    if (iss_q.second) begin
                        iss_d.st   = U_IDLE;
                        iss_d.done = 1'b1;
                        iss_d.ok   = 1'b1;
                    end else begin
                        // first pass applied: drop request one cycle, then repeat
                        iss_d.st     = U_GAP;
                        iss_d.second = 1'b1;
                        iss_d.tmr    = '0;
                    end
                end else if (iss_q.tmr == TMR_LAST) begin
                    iss_d.st   = U_IDLE;
                    iss_d.done = 1'b1;
                    iss_d.ok   = 1'b0;
                end else begin
                    iss_d.tmr = iss_q.tmr + TMR_W'(1);
                end
            end
            U_GAP: begin
                iss_d.st  = U_REQ;
                iss_d.tmr = '0;
            end
            default: iss_d.st = U_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            iss_q <= '{st: U_IDLE, second: 1'b0, tmr: '0, done: 1'b0, ok: 1'b0};
        end else begin
            iss_q <= iss_d;
        end
    end

    assign req_o  = (iss_q.st == U_REQ);
    assign done_o = iss_q.done;
    assign ok_o   = iss_q.ok;

endmodule

// File: rtl/tsw_window_track.sv
// Tracks the current and the longest run of passing taps.
module tsw_window_track #(
    parameter int TAP_W = 6,
    parameter int LEN_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             ev_i,
    input  logic             pass_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic [LEN_W-1:0] best_len_o,
    output logic [TAP_W-1:0] end_tap_o
);
    typedef struct packed {
        logic [LEN_W-1:0] cur;
        logic [LEN_W-1:0] best;
        logic [TAP_W-1:0] endt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [LEN_W-1:0] cur_inc;

    always_comb begin
        trk_d   = trk_q;
        cur_inc = trk_q.cur + LEN_W'(1);
        if (clr_i) begin
            trk_d = '0;
        end else if (ev_i) begin
            if (pass_i) begin
                trk_d.cur = cur_inc;
                // strict compare: an equal-length later run keeps the earlier one
                if (cur_inc > trk_q.best) begin
                    trk_d.best = cur_inc;
                    trk_d.endt = tap_i;
                end
            end else begin
                trk_d.cur = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign best_len_o = trk_q.best;
    assign end_tap_o  = trk_q.endt;

endmodule

// File: rtl/tsw_sweep_engine.sv
// Sweeps receive sampling taps, then programs the centre of the longest passing run.
module tsw_sweep_engine
    import tsw_pkg::*;
#(
    parameter int TAP_W       = 6,
    parameter int TAP_COUNT   = 40,
    parameter int UPD_TIMEOUT = 64
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             start_i,
    output logic [TAP_W-1:0]                 tap_o,
    output logic                             upd_req_o,
    input  logic                             upd_ack_i,
    output logic                             xfer_start_o,
    input  logic                             xfer_done_i,
    input  logic                             xfer_pass_i,
    output logic                             busy_o,
    output logic                             done_o,
    output logic                             err_o,
    output logic [TAP_W-1:0]                 best_tap_o,
    output logic [$clog2(TAP_COUNT+1)-1:0]   win_len_o
);
    localparam int LEN_W = $clog2(TAP_COUNT + 1);
    localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(TAP_COUNT - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [TAP_W-1:0] tap;
        logic             go;
        logic             xs;
        logic             done;
        logic             err;
        logic [TAP_W-1:0] res_tap;
        logic [LEN_W-1:0] res_len;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             upd_done, upd_ok;
    logic             trk_clr, trk_ev, trk_pass;
    logic [LEN_W-1:0] best_len;
    logic [TAP_W-1:0] end_tap;
    logic [TAP_W-1:0] centre_tap;

    tsw_upd_issuer #(
        .UPD_TIMEOUT(UPD_TIMEOUT)
    ) u_issuer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (seq_q.go),
        .ack_i  (upd_ack_i),
        .req_o  (upd_req_o),
        .done_o (upd_done),
        .ok_o   (upd_ok)
    );

    tsw_window_track #(
        .TAP_W(TAP_W),
        .LEN_W(LEN_W)
    ) u_track (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (trk_clr),
        .ev_i       (trk_ev),
        .pass_i     (trk_pass),
        .tap_i      (seq_q.tap),
        .best_len_o (best_len),
        .end_tap_o  (end_tap)
    );

    assign trk_clr  = (seq_q.st == S_IDLE) && start_i;
    assign trk_ev   = ((seq_q.st == S_UPD) && upd_done && !upd_ok)
                    || ((seq_q.st == S_XFER) && xfer_done_i);
    assign trk_pass = (seq_q.st == S_XFER) && xfer_pass_i;

    // end tap is never below best_len-1, so the difference stays in range
    assign centre_tap = end_tap - TAP_W'(best_len >> 1);

    always_comb begin
        seq_d      = seq_q;
        seq_d.go   = 1'b0;
        seq_d.xs   = 1'b0;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        unique case (seq_q.st)
            S_IDLE: begin
                if (start_i) begin
                    seq_d.st      = S_UPD;
                    seq_d.tap     = '0;
                    seq_d.go      = 1'b1;
                    seq_d.res_tap = '0;
                    seq_d.res_len = '0;
                end
            end
            S_UPD: begin
                if (upd_done) begin
                    if (upd_ok) begin
                        seq_d.st = S_XFER;
                        seq_d.xs = 1'b1;
                    end else begin
                        seq_d.st = S_NEXT;
                    end
                end
            end
            S_XFER: begin
                if (xfer_done_i) begin
                    seq_d.st = S_NEXT;
                end
            end
            S_NEXT: begin
                if (seq_q.tap == TAP_LAST) begin
                    if (best_len == '0) begin
                        seq_d.st  = S_IDLE;
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.st      = S_FINAL;
                        seq_d.tap     = centre_tap;
                        seq_d.go      = 1'b1;
                        seq_d.res_tap = centre_tap;
                        seq_d.res_len = best_len;
                    end
                end else begin
                    seq_d.st  = S_UPD;
                    seq_d.tap = seq_q.tap + TAP_W'(1);
                    seq_d.go  = 1'b1;
                end
            end
            S_FINAL: begin
                if (upd_done) begin
                    seq_d.st   = S_IDLE;
                    seq_d.done = upd_ok;
                    seq_d.err  = !upd_ok;
                end
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: S_IDLE, tap: '0, go: 1'b0, xs: 1'b0, done: 1'b0,
                       err: 1'b0, res_tap: '0, res_len: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tap_o        = seq_q.tap;
    assign xfer_start_o = seq_q.xs;
    assign busy_o       = (seq_q.st != S_IDLE);
    assign done_o       = seq_q.done;
    assign err_o        = seq_q.err;
    assign best_tap_o   = seq_q.res_tap;
    assign win_len_o    = seq_q.res_len;

endmodule

// File: rtl/tsw_sweep_checker.sv
module tsw_sweep_checker #(
    parameter int TAP_W       = 6,
    parameter int TAP_COUNT   = 40,
    parameter int UPD_TIMEOUT = 64
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [TAP_W-1:0] tap_o,
    input logic             upd_req_o,
    input logic             xfer_start_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             err_o
);
    localparam int RUN_W = $clog2(UPD_TIMEOUT + 2);

    logic [RUN_W-1:0] run_q;

    // cycles the request has already been high before the current one
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (!upd_req_o) begin
            run_q <= '0;
        end else if (run_q != {RUN_W{1'b1}}) begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    a_r2_tap_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (int'(tap_o) <= TAP_COUNT - 1));

    a_r2_tap_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_req_o |=> (!upd_req_o || $stable(tap_o)));

    a_r3_wait_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_req_o |-> (int'(run_q) < UPD_TIMEOUT));

    a_r4_no_xfer_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_start_o |-> !upd_req_o);

    a_r4_xfer_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_start_o |=> !xfer_start_o);

    a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && err_o));

    a_r10_idle_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o || err_o) |-> !busy_o);

endmodule

bind tsw_sweep_engine tsw_sweep_checker #(
    .TAP_W(TAP_W),
    .TAP_COUNT(TAP_COUNT),
    .UPD_TIMEOUT(UPD_TIMEOUT)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tap_o        (tap_o),
    .upd_req_o    (upd_req_o),
    .xfer_start_o (xfer_start_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/tb_tsw_sweep_engine.sv
`timescale 1ns/1ps
module tb_tsw_sweep_engine;
    localparam int TAP_W = 6;
    localparam int TAP_COUNT = 40;
    localparam int TMO = 6;
    localparam int LEN_W = $clog2(TAP_COUNT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic upd_ack_i = 1'b0;
    logic xfer_done_i = 1'b0;
    logic xfer_pass_i = 1'b0;
    logic [TAP_W-1:0] tap_o;
    logic upd_req_o, xfer_start_o, busy_o, done_o, err_o;
    logic [TAP_W-1:0] best_tap_o;
    logic [LEN_W-1:0] win_len_o;

    always #2.5 clk = ~clk;

    tsw_sweep_engine #(.TAP_W(TAP_W), .TAP_COUNT(TAP_COUNT), .UPD_TIMEOUT(TMO)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .tap_o(tap_o),
        .upd_req_o(upd_req_o), .upd_ack_i(upd_ack_i), .xfer_start_o(xfer_start_o),
        .xfer_done_i(xfer_done_i), .xfer_pass_i(xfer_pass_i), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .best_tap_o(best_tap_o), .win_len_o(win_len_o)
    );

    int n_check = 0;
    int n_err = 0;
    bit pass_map[TAP_COUNT];
    bit stuck_map[TAP_COUNT];
    int exp_q[$];
    int req_seen = 0;
    int xs_cnt = 0;
    int stuck_len = -1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_check++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // datapath model: acknowledges each update request two cycles after it rises
    initial begin
        bit served = 0;
        bit stuck_now = 0;
        int wait_ct = 0;
        int hi_cnt = 0;
        forever begin
            @(negedge clk);
            upd_ack_i = 1'b0;
            if (!upd_req_o) begin
                if (served && stuck_now) stuck_len = hi_cnt;
                served = 0;
            end else if (!served) begin
                int e;
                served = 1;
                hi_cnt = 1;
                req_seen++;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                if (req_seen > 2 * TAP_COUNT)
                    chk(int'(tap_o) == e, "R7 final tap request", int'(tap_o), e);
                else
                    chk(int'(tap_o) == e, "R2 tap order", int'(tap_o), e);
                stuck_now = stuck_map[tap_o] && (req_seen % 2 == 0) && (req_seen <= 2 * TAP_COUNT);
                wait_ct = 2;
            end else begin
                hi_cnt++;
                if (wait_ct > 0) begin
                    wait_ct--;
                    if (wait_ct == 0 && !stuck_now) upd_ack_i = 1'b1;
                end
            end
        end
    end

    // transfer checker model: answers three cycles after a launch
    initial begin
        int xs_ct = 0;
        int xs_tap = 0;
        forever begin
            @(negedge clk);
            xfer_done_i = 1'b0;
            xfer_pass_i = 1'b0;
            if (xs_ct > 0) begin
                xs_ct--;
                if (xs_ct == 0) begin
                    xfer_done_i = 1'b1;
                    xfer_pass_i = pass_map[xs_tap];
                end
            end
            if (xfer_start_o) begin
                chk(!upd_req_o, "R4 launch outside request", int'(upd_req_o), 0);
                xs_cnt++;
                xs_ct = 3;
                xs_tap = int'(tap_o);
            end
        end
    end

    task automatic set_run(input int lo, input int hi);
        for (int i = lo; i <= hi; i++) pass_map[i] = 1'b1;
    endtask

    task automatic clear_maps();
        for (int i = 0; i < TAP_COUNT; i++) begin
            pass_map[i] = 1'b0;
            stuck_map[i] = 1'b0;
        end
    endtask

    task automatic run_sweep(input string tag, input bit poke_start);
        int cur = 0, best = 0, endt = 0, fin = 0, nstuck = 0;
        int cyc = 0;
        bit got_done = 0, got_err = 0;
        for (int i = 0; i < TAP_COUNT; i++) begin
            bit good;
            good = pass_map[i] && !stuck_map[i];
            if (stuck_map[i]) nstuck++;
            if (good) begin
                cur++;
                if (cur > best) begin best = cur; endt = i; end
            end else cur = 0;
        end
        fin = endt - best / 2;
        exp_q.delete();
        for (int i = 0; i < TAP_COUNT; i++) begin
            exp_q.push_back(i);
            exp_q.push_back(i);
        end
        if (best > 0) begin
            exp_q.push_back(fin);
            exp_q.push_back(fin);
        end
        req_seen = 0;
        xs_cnt = 0;
        stuck_len = -1;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, {tag, " R10 busy after start"}, int'(busy_o), 1);
        while (!done_o && !err_o && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke_start && cyc == 100) start_i = 1'b1;
            if (poke_start && cyc == 101) start_i = 1'b0;
        end
        if (cyc >= 20000) begin
            chk(0, {tag, " watchdog"}, cyc, 20000);
            return;
        end
        got_done = done_o;
        got_err = err_o;
        chk(busy_o == 1'b0, {tag, " R10 idle on end pulse"}, int'(busy_o), 0);
        if (best > 0) begin
            chk(got_done && !got_err, {tag, " R7 done pulse"}, int'(got_done), 1);
            chk(int'(best_tap_o) == fin, {tag, " R7 chosen tap"}, int'(best_tap_o), fin);
            chk(int'(win_len_o) == best, {tag, " R5 window length"}, int'(win_len_o), best);
            chk(int'(tap_o) == fin, {tag, " R7 tap left programmed"}, int'(tap_o), fin);
        end else begin
            chk(got_err && !got_done, {tag, " R8 error pulse"}, int'(got_err), 1);
            chk(int'(win_len_o) == 0, {tag, " R8 zero length"}, int'(win_len_o), 0);
        end
        chk(req_seen == 2 * TAP_COUNT + (best > 0 ? 2 : 0), {tag, " R2 request count"},
            req_seen, 2 * TAP_COUNT + (best > 0 ? 2 : 0));
        chk(xs_cnt == TAP_COUNT - nstuck, {tag, " R4 transfer count"}, xs_cnt, TAP_COUNT - nstuck);
        if (nstuck > 0)
            chk(stuck_len == TMO, {tag, " R3 abandoned request length"}, stuck_len, TMO);
        @(negedge clk);
        chk(!done_o && !err_o, {tag, " R7 single-cycle end pulse"}, int'(done_o || err_o), 0);
        chk(int'(best_tap_o) == (best > 0 ? fin : 0), {tag, " R7 result held"},
            int'(best_tap_o), (best > 0 ? fin : 0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog global", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_check, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_o && !upd_req_o && !xfer_start_o,
            "R1 reset controls", int'({busy_o, done_o, err_o, upd_req_o, xfer_start_o}), 0);
        chk(tap_o == '0 && best_tap_o == '0 && win_len_o == '0, "R1 reset values",
            int'(tap_o) + int'(best_tap_o) + int'(win_len_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        clear_maps(); set_run(10, 19);
        run_sweep("R5 mid run, R9 start while busy", 1'b1);

        clear_maps(); set_run(3, 7); set_run(20, 24);
        run_sweep("R6 tie keeps first", 1'b0);

        clear_maps();
        run_sweep("R8 nothing passes", 1'b0);

        clear_maps(); set_run(5, 20); stuck_map[12] = 1'b1;
        run_sweep("R3 stuck update splits run", 1'b0);

        clear_maps(); pass_map[0] = 1'b1;
        run_sweep("R2 only tap 0", 1'b0);

        clear_maps(); pass_map[TAP_COUNT-1] = 1'b1;
        run_sweep("R2 only last tap", 1'b0);

        clear_maps(); set_run(0, TAP_COUNT - 1);
        run_sweep("R7 full range", 1'b0);

        $display("CHECKS %0d ERRORS %0d", n_check, n_err);
        $finish;
    end

endmodule